// File: doc/BRIEF.md
# Dual-Word Interrupt Cause Aggregator

This block gathers 64 level-sensitive interrupt sources into a 64-bit cause vector. It gates that vector with a 64-bit CPU mask and drives one CPU interrupt line. Software programs the mask through a small register port, as two 32-bit halves, and can read the cause vector back as two words.

The block also offers a "select cause" word. It tells software, in a single read, which half of the cause vector holds masked pending work. If only the upper half has masked pending sources, the read returns the upper cause word with bit 30 set. If both halves have them, it returns the lower cause word with bit 31 set. In every other case it returns the lower cause word unchanged.

Several source numbers are reserved and never reach the cause vector: 29 to 31, 35, 51 to 55 and 61 to 63. Sources 56 to 59 are the four byte-group interrupts of a general-purpose I/O block. Priority encoding and vectoring are left to software.

Top module: `intr_cause_agg`

## Requirements
- R1: On each clock edge out of reset, cause bit n takes the level of source input bit n. It is set while the level is high and cleared once the level is low.
- R2: The reserved cause bits 29, 30, 31, 35, 51 to 55 and 61 to 63 always read as zero and never raise the CPU interrupt.
- R3: A write to address 2 loads mask[31:0] and a write to address 3 loads mask[63:32]. Each write leaves the other half unchanged, and both halves read back at the same addresses.
- R4: The CPU interrupt is a register holding the OR of (cause AND mask). It changes two clock edges after a source level change and one edge after a mask write.
- R5: A read of address 4 (select cause), when masked pending bits exist only in cause[63:32], returns cause[63:32] with bit 30 set.
- R6: A read of address 4, when masked pending bits exist in both halves, returns cause[31:0] with bit 31 set.
- R7: A read of address 4, when masked pending bits exist only in cause[31:0] or nowhere, returns cause[31:0] unchanged.
- R8: Read data is registered and is valid on the clock edge after the one that samples rd_en. Address 0 reads cause[31:0], address 1 reads cause[63:32], and any other unmapped address reads zero. After reset, the cause vector, the mask and the interrupt are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | 64 | Interrupt source levels, bit n is source n |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address (word index) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| cpu_irq | output | 1 | CPU interrupt line |

## Verification
The results of this block arrive at different times after their stimulus:
- A source change reaches the cause vector on the next edge and the interrupt line one edge later.
- A mask write reaches the interrupt one edge after it is written.
- Read data appears one edge after the read strobe.

The bench drives every input on the falling edge and waits a fixed settle time after changing the sources before it samples the interrupt. It pushes the expected value of each read into a queue when the read is issued. A monitor pops that value at the falling edge after the capturing edge, so every compare lands in the cycle in which the result is due. One check also confirms that the interrupt is still low a single cycle after a source rises.

// File: rtl/iagg_pkg.sv
// Package: shared widths, register addresses and the reserved-source mask
// for the interrupt cause aggregator.
package iagg_pkg;
    localparam int SRC_N  = 64;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 3;

    // Register word addresses.
    localparam logic [ADDR_W-1:0] A_CAUSE_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_CAUSE_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_MASK_LO  = 3'd2;
    localparam logic [ADDR_W-1:0] A_MASK_HI  = 3'd3;
    localparam logic [ADDR_W-1:0] A_SELECT   = 3'd4;

    // Reserved sources: 29-31, 35, 51-55, 61-63.
    localparam logic [SRC_N-1:0] RSVD_MASK = 64'hE0F8_0008_E000_0000;

    // Flag positions inside the select-cause word.
    localparam int FLAG_HI_ONLY = 30;
    localparam int FLAG_BOTH    = 31;
endpackage

// File: rtl/iagg_cause_capture.sv
// Module: iagg_cause_capture
// Samples the source levels into the cause vector once per clock and
// forces the reserved positions to zero.
// Assumes the sources are already synchronous to clk.
module iagg_cause_capture #(
    parameter int              N    = 64,
    parameter logic [N-1:0]    RSVD = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_lvl,
    output logic [N-1:0] cause
);
    logic valid_q;

    // Capture the level of each source, with reserved bits held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) cause <= '0;
        else        cause <= src_lvl & ~RSVD;
    end

    // Mark cycles whose previous edge was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= 1'b1;
    end

    p_cause_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (cause == ($past(src_lvl) & ~RSVD)));

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cause & RSVD) == '0);
endmodule

// File: rtl/iagg_mask_regs.sv
// Module: iagg_mask_regs
// Holds the CPU mask as two independently written halves.
// Assumes at most one write per cycle, selected by the write enables.
module iagg_mask_regs #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we_lo,
    input  logic           we_hi,
    input  logic [W-1:0]   wdata,
    output logic [2*W-1:0] mask
);
    // Load the lower half of the mask on its own write.
    always_ff @(posedge clk) begin
        if (!rst_n)     mask[W-1:0] <= '0;
        else if (we_lo) mask[W-1:0] <= wdata;
    end

    // Load the upper half of the mask on its own write.
    always_ff @(posedge clk) begin
        if (!rst_n)     mask[2*W-1:W] <= '0;
        else if (we_hi) mask[2*W-1:W] <= wdata;
    end

    p_lo_keeps_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we_lo && !we_hi) |=> (mask[2*W-1:W] == $past(mask[2*W-1:W])));

    p_hi_keeps_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we_hi && !we_lo) |=> (mask[W-1:0] == $past(mask[W-1:0])));
endmodule

// File: rtl/iagg_select.sv
// Module: iagg_select
// Builds the select-cause word from the cause vector and the mask.
// Purely combinational; assumes the flag bit positions are reserved
// positions in the returned word, so the flags never overlap live cause bits.
module iagg_select #(
    parameter int W       = 32,
    parameter int F_HI    = 30,
    parameter int F_BOTH  = 31
) (
    input  logic [2*W-1:0] cause,
    input  logic [2*W-1:0] mask,
    output logic [W-1:0]   sel_word,
    output logic           any_pend
);
    logic [2*W-1:0] pend;
    logic           lo_any, hi_any;

    // Choose the cause half and flag from which halves hold masked work.
    always_comb begin
        pend     = cause & mask;
        lo_any   = |pend[W-1:0];
        hi_any   = |pend[2*W-1:W];
        any_pend = lo_any | hi_any;
        sel_word = cause[W-1:0];
        if (hi_any && !lo_any) begin
            sel_word       = cause[2*W-1:W];
            sel_word[F_HI] = 1'b1;
        end else if (hi_any && lo_any) begin
            sel_word[F_BOTH] = 1'b1;
        end
    end
endmodule

// File: rtl/intr_cause_agg.sv
// Module: intr_cause_agg (top)
// Aggregates 64 level interrupt sources into a cause vector, masks it with
// a two-word CPU mask, drives a registered CPU interrupt and serves reads
// of cause, mask and the select-cause word with one cycle of latency.
// Assumes a synchronous register port with separate read and write strobes.
module intr_cause_agg
    import iagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  src_lvl,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              cpu_irq
);
    localparam int HALF = SRC_N / 2;

    logic [SRC_N-1:0]  cause;
    logic [SRC_N-1:0]  mask;
    logic [WORD_W-1:0] sel_word;
    logic              any_pend;
    logic              valid_q;

    iagg_cause_capture #(.N(SRC_N), .RSVD(RSVD_MASK)) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_lvl (src_lvl),
        .cause   (cause)
    );

    iagg_mask_regs #(.W(HALF)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .we_lo (wr_en && addr == A_MASK_LO),
        .we_hi (wr_en && addr == A_MASK_HI),
        .wdata (wdata),
        .mask  (mask)
    );

    iagg_select #(.W(HALF), .F_HI(FLAG_HI_ONLY), .F_BOTH(FLAG_BOTH)) u_sel (
        .cause    (cause),
        .mask     (mask),
        .sel_word (sel_word),
        .any_pend (any_pend)
    );

    // Register the CPU interrupt from any masked pending cause.
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_irq <= 1'b0;
        else        cpu_irq <= any_pend;
    end

    // Register the read data selected by the address.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (rd_en) begin
            case (addr)
                A_CAUSE_LO: rdata <= cause[HALF-1:0];
                A_CAUSE_HI: rdata <= cause[SRC_N-1:HALF];
                A_MASK_LO:  rdata <= mask[HALF-1:0];
                A_MASK_HI:  rdata <= mask[SRC_N-1:HALF];
                A_SELECT:   rdata <= sel_word;
                default:    rdata <= '0;
            endcase
        end
    end

    // Mark cycles whose previous edge was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= 1'b1;
    end

    p_irq_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (cpu_irq == |($past(cause) & $past(mask))));

    p_rsvd_no_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause & mask & ~RSVD_MASK) == '0) |=> !cpu_irq);

    p_hi_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_word[FLAG_HI_ONLY] |-> ((cause[HALF-1:0] & mask[HALF-1:0]) == '0));

    p_both_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_word[FLAG_BOTH] |-> ((cause[SRC_N-1:HALF] & mask[SRC_N-1:HALF]) != '0));

    p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_word[FLAG_BOTH:FLAG_HI_ONLY]));

    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !rd_en) |=> $stable(rdata));
endmodule

// File: tb/tb_intr_cause_agg.sv
// Scoreboard bench: the driver pushes the expected value of each read into
// a queue; the monitor pops and compares when read data is due.
module tb_intr_cause_agg;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] src_lvl;
    logic        wr_en, rd_en;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        cpu_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    intr_cause_agg dut (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .cpu_irq(cpu_irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Drive sources, then let cause and interrupt settle (two edges needed).
    task automatic set_src(input logic [63:0] v);
        @(negedge clk);
        src_lvl = v;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compare the read data one edge after the sampling edge.
    initial begin
        forever begin
            logic pend;
            @(posedge clk);
            pend = rd_en && rst_n;
            @(negedge clk);
            if (pend) begin
                if (exp_q.size() == 0) begin
                    n_checks++; n_fail++;
                    $display("FAIL R8: unexpected read data actual %h expected none", rdata);
                end else begin
                    check(rdata, exp_q.pop_front(), tag_q.pop_front());
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; src_lvl = '0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state.
        check({31'd0, cpu_irq}, 32'd0, "R8 reset irq");
        rd(3'd0, 32'h0, "R8 reset cause lo");
        rd(3'd2, 32'h0, "R8 reset mask lo");
        rd(3'd3, 32'h0, "R8 reset mask hi");

        // R1 source 5 high, unmasked -> cause bit, no irq.
        set_src(64'h20);
        rd(3'd0, 32'h20, "R1 cause lo bit5");
        check({31'd0, cpu_irq}, 32'd0, "R4 irq masked off");

        // R4 mask write raises irq.
        wr(3'd2, 32'h20);
        @(negedge clk);
        check({31'd0, cpu_irq}, 32'd1, "R4 irq after mask");
        rd(3'd4, 32'h20, "R7 select low only");

        // R3 mask hi write keeps lo.
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd2, 32'h20, "R3 mask lo kept");
        rd(3'd3, 32'hFFFF_FFFF, "R3 mask hi loaded");

        // R6 both halves pending.
        set_src(64'h0000_0100_0000_0020);
        rd(3'd4, 32'h8000_0020, "R6 select both");
        rd(3'd1, 32'h0000_0100, "R1 cause hi bit40");

        // R5 upper only.
        set_src(64'h0000_0100_0000_0000);
        rd(3'd4, 32'h4000_0100, "R5 select hi only");
        check({31'd0, cpu_irq}, 32'd1, "R4 irq from upper");

        // R2 reserved bits read zero.
        set_src('1);
        rd(3'd0, 32'h1FFF_FFFF, "R2 cause lo reserved");
        rd(3'd1, 32'h1F07_FFF7, "R2 cause hi reserved");

        // R2 reserved source cannot raise irq; R3 lo write keeps hi.
        wr(3'd2, 32'h0);
        rd(3'd3, 32'hFFFF_FFFF, "R3 mask hi kept");
        set_src(64'hE0F8_0008_E000_0000);
        check({31'd0, cpu_irq}, 32'd0, "R2 reserved no irq");
        rd(3'd4, 32'h0, "R7 select none");

        // R1 GPIO group source 56 with level drop clearing it.
        set_src(64'h0100_0000_0000_0000);
        rd(3'd1, 32'h0100_0000, "R1 cause hi bit56");
        set_src(64'h0);
        rd(3'd1, 32'h0, "R1 cause cleared");
        check({31'd0, cpu_irq}, 32'd0, "R4 irq dropped");

        // R4 latency: irq low one cycle after source rises, high after two.
        @(negedge clk);
        src_lvl = 64'h0000_0001_0000_0000;
        @(negedge clk);
        check({31'd0, cpu_irq}, 32'd0, "R4 irq not yet");
        @(negedge clk);
        check({31'd0, cpu_irq}, 32'd1, "R4 irq due");

        // R8 unmapped address.
        rd(3'd6, 32'h0, "R8 unmapped");
        repeat (3) @(negedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule